// File: doc/BRIEF.md
# Disk controller register interface

This block is the register front end of a cartridge-disk controller on a 16-bit memory-mapped bus. Through it, software programs a transfer: word count, bus address, disk address, a data buffer, and a control/status word that holds a function code and a go bit. The block also holds a read-only drive status word and a read-only error word. A write that sets go is decoded right away. A control reset clears the controller. A request that asks for a mode the controller does not support is turned into a programming error. Read, write, write-check and write-lock requests become one-cycle start strobes for a separate transfer engine. When interrupts are enabled, the block raises a one-cycle completion interrupt request.

The bus side uses a 3-bit word index and two byte-lane enables. Reads are combinational. The ready bit and the summary error bit of the control/status word are produced when it is read and are not stored. The write-lock command sets a bit in an 8-bit per-drive lock mask, and the transfer engine consults that mask.

Top module: `dskc_regs`

## Requirements
- R1: After rst_ni is released, the registers read as follows: drive status 0x09C0 (bits 6, 7, 8 and 11 set), error 0, control/status 0x0080, and word count, bus address, disk address and data buffer all 0. The lock mask is 0, and no start strobe or interrupt is active.
- R2: The word indices are 3 (word count), 4 (bus address), 5 (disk address) and 7 (data buffer). Each of these reads back what was written to it. Index 6 always reads 0, and writes to it have no effect.
- R3: Writes to index 0 (drive status) and index 1 (error) change neither register.
- R4: Reading control/status at index 2 always returns bit 7 (ready) as 1. Bit 15 reads 1 exactly when the error register is nonzero.
- R5: Byte lane 0 (be_i[0]) covers bits 7:0 and lane 1 covers bits 15:8. A write with only lane 1 enabled replaces bits 15:8 of control/status and starts no command. A write with lane 0 enabled merges the enabled lanes and is then decoded as a command. The go bit (bit 0) always reads back as 0.
- R6: Function 0 (bits 3:1) with go set is a control reset. It clears the error, word count, disk address and data buffer registers. It leaves only the ready bit in control/status and clears bits 15:12 of drive status. The bus address is kept.
- R7: A command-path write with bit 10 (format) or bit 11 (single location) set loads the error register with 0x0800 and starts nothing.
- R8: With go set, functions 1, 2, 3 and 7 pulse start_write_o, start_read_o, start_wchk_o and start_lock_o respectively, for one cycle, in the cycle after the write. Functions 4, 5 and 6, and any write without go, pulse no strobe.
- R9: When go is accepted and the written bit 6 (interrupt enable) is set, irq_o pulses for one cycle, one cycle after the start strobe. A control reset raises no interrupt. The level output is 5 and the vector output is octal 220.
- R10: A write-lock command sets bit (disk address bits 15:13) of lock_mask_o, visible in the cycle after the write. Bits already set stay set.
- R11: A one-cycle bus_rst_i clears control/status to 0, so it reads 0x0080 when no error is pending.
- R12: xfer_addr_o is control/status bits 5:4 concatenated above the 16-bit bus address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | Bus reset pulse, clears control/status |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 3 | Word index of the register |
| be_i | input | 2 | Byte-lane enables |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| start_write_o | output | 1 | Start a write transfer |
| start_read_o | output | 1 | Start a read transfer |
| start_wchk_o | output | 1 | Start a write-check transfer |
| start_lock_o | output | 1 | Write-lock command issued |
| lock_mask_o | output | 8 | Per-drive write-lock mask |
| xfer_wc_o | output | 16 | Word count for the engine |
| xfer_addr_o | output | 18 | Extended bus address for the engine |
| xfer_da_o | output | 16 | Disk address for the engine |
| irq_o | output | 1 | Completion interrupt request pulse |
| irq_lvl_o | output | 3 | Interrupt priority level |
| irq_vec_o | output | 9 | Interrupt vector |

## Verification
The assertions assume that rst_ni is held across at least one clock edge, so that the lock-mask and interrupt history start from reset values. They also assume that wr_en_i is low while rst_ni is asserted. The bench drives every bus write for exactly one cycle, changing inputs on the falling edge, and keeps wr_en_i low during reset. It sweeps all eight function codes with interrupt enable both off and on, and all eight drive numbers for the lock mask. It issues bus_rst_i only while no write is in flight.

// File: rtl/dskc_pkg.sv
package dskc_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned DRV_W = 3;

  typedef enum logic [2:0] {
    SEL_DS = 3'd0, SEL_ER = 3'd1, SEL_CS = 3'd2, SEL_WC = 3'd3,
    SEL_BA = 3'd4, SEL_DA = 3'd5, SEL_NONE = 3'd6, SEL_DB = 3'd7
  } reg_sel_e;

  typedef enum logic [2:0] {
    FN_CRESET = 3'd0, FN_WRITE = 3'd1, FN_READ = 3'd2, FN_WCHK = 3'd3,
    FN_SEEK = 3'd4, FN_RCHK = 3'd5, FN_DRST = 3'd6, FN_WLOCK = 3'd7
  } fn_e;

  localparam int unsigned CS_GO  = 0;
  localparam int unsigned CS_IE  = 6;
  localparam int unsigned CS_RDY = 7;
  localparam int unsigned CS_FMT = 10;
  localparam int unsigned CS_SGL = 11;
  localparam int unsigned ER_PGE = 11;
  localparam logic [REG_W-1:0] DS_INIT = 16'h09C0;

  typedef struct packed {
    logic go_ok;
    logic pge;
    logic creset;
    logic st_write;
    logic st_read;
    logic st_wchk;
    logic st_lock;
  } cmd_t;
endpackage

// File: rtl/dskc_cmd_dec.sv
module dskc_cmd_dec
  import dskc_pkg::*;
(
  input  logic [REG_W-1:0] cs_new_i,
  input  logic             launch_i,
  output cmd_t             cmd_o
);
  fn_e fn;
  assign fn = fn_e'(cs_new_i[3:1]);

  always_comb begin
    cmd_o          = '0;
    cmd_o.pge      = launch_i & (cs_new_i[CS_FMT] | cs_new_i[CS_SGL]);
    cmd_o.go_ok    = launch_i & cs_new_i[CS_GO] & ~cmd_o.pge;
    if (cmd_o.go_ok) begin
      unique case (fn)
        FN_CRESET: cmd_o.creset   = 1'b1;
        FN_WRITE:  cmd_o.st_write = 1'b1;
        FN_READ:   cmd_o.st_read  = 1'b1;
        FN_WCHK:   cmd_o.st_wchk  = 1'b1;
        FN_WLOCK:  cmd_o.st_lock  = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/dskc_lock_mask.sv
module dskc_lock_mask
  import dskc_pkg::*;
#(
  parameter int unsigned NDRIVES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic [DRV_W-1:0]   drive_i,
  output logic [NDRIVES-1:0] mask_o
);
  logic [NDRIVES-1:0] mask_q;

  for (genvar g = 0; g < NDRIVES; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mask_q[g] <= 1'b0;
      else if (set_i && drive_i == DRV_W'(g))        mask_q[g] <= 1'b1;
    end
  end

  assign mask_o = mask_q;

  // R10
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & $past(mask_q)) == $past(mask_q));
endmodule

// File: rtl/dskc_irq_pulse.sv
module dskc_irq_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic irq_o
);
  logic fire_q, irq_q;

  // first stage lines up with the start strobes, second trails by one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      fire_q <= fire_i;
      irq_q  <= fire_q;
    end
  end

  assign irq_o = irq_q;

  // R9
  irq_after_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(fire_i, 2));
endmodule

// File: rtl/dskc_regs.sv
module dskc_regs
  import dskc_pkg::*;
#(
  parameter int unsigned NDRIVES = 8,
  parameter logic [2:0]  IRQ_LVL = 3'd5,
  parameter logic [8:0]  IRQ_VEC = 9'o220
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_rst_i,
  input  logic               wr_en_i,
  input  logic [2:0]         addr_i,
  input  logic [1:0]         be_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               start_write_o,
  output logic               start_read_o,
  output logic               start_wchk_o,
  output logic               start_lock_o,
  output logic [NDRIVES-1:0] lock_mask_o,
  output logic [REG_W-1:0]   xfer_wc_o,
  output logic [REG_W+1:0]   xfer_addr_o,
  output logic [REG_W-1:0]   xfer_da_o,
  output logic               irq_o,
  output logic [2:0]         irq_lvl_o,
  output logic [8:0]         irq_vec_o
);
  localparam logic [REG_W-1:0] CS_RST = REG_W'(1) << CS_RDY;
  localparam logic [REG_W-1:0] ER_PGE_V = REG_W'(1) << ER_PGE;

  logic [REG_W-1:0] ds_q, er_q, cs_q, wc_q, ba_q, da_q, db_q;
  logic [REG_W-1:0] wmask, cs_new, cs_rd;
  logic             launch, fire;
  reg_sel_e         sel;
  cmd_t             cmd;

  function automatic logic [REG_W-1:0] merge_f(input logic [REG_W-1:0] old_v,
                                               input logic [REG_W-1:0] new_v,
                                               input logic [REG_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  assign sel    = reg_sel_e'(addr_i);
  assign wmask  = {{8{be_i[1]}}, {8{be_i[0]}}};
  assign cs_new = merge_f(cs_q, wdata_i, wmask);
  assign launch = wr_en_i & (sel == SEL_CS) & be_i[0];
  assign cs_rd  = {(er_q != '0), cs_q[14:8], 1'b1, cs_q[6:0]};

  dskc_cmd_dec u_dec (
    .cs_new_i (cs_new),
    .launch_i (launch),
    .cmd_o    (cmd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ds_q <= DS_INIT;
      er_q <= '0;
      cs_q <= '0;
      wc_q <= '0;
      ba_q <= '0;
      da_q <= '0;
      db_q <= '0;
      start_write_o <= 1'b0;
      start_read_o  <= 1'b0;
      start_wchk_o  <= 1'b0;
      start_lock_o  <= 1'b0;
    end else begin
      start_write_o <= cmd.st_write;
      start_read_o  <= cmd.st_read;
      start_wchk_o  <= cmd.st_wchk;
      start_lock_o  <= cmd.st_lock;
      if (wr_en_i) begin
        unique case (sel)
          SEL_WC: wc_q <= merge_f(wc_q, wdata_i, wmask);
          SEL_BA: ba_q <= merge_f(ba_q, wdata_i, wmask);
          SEL_DA: da_q <= merge_f(da_q, wdata_i, wmask);
          SEL_DB: db_q <= merge_f(db_q, wdata_i, wmask);
          SEL_CS: begin
            if (cmd.creset) begin
              er_q <= '0;
              cs_q <= CS_RST;
              wc_q <= '0;
              da_q <= '0;
              db_q <= '0;
              ds_q <= {4'h0, ds_q[11:0]};
            end else begin
              cs_q <= cs_new & ~(REG_W'(1) << CS_GO);
              if (cmd.pge) er_q <= ER_PGE_V;
            end
          end
          default: ;
        endcase
      end
      if (bus_rst_i) cs_q <= '0;
    end
  end

  assign fire = cmd.go_ok & cs_new[CS_IE] & ~cmd.creset;

  dskc_irq_pulse u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .irq_o  (irq_o)
  );

  dskc_lock_mask #(.NDRIVES(NDRIVES)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (cmd.st_lock),
    .drive_i (da_q[15:13]),
    .mask_o  (lock_mask_o)
  );

  always_comb begin
    unique case (sel)
      SEL_DS:  rdata_o = ds_q;
      SEL_ER:  rdata_o = er_q;
      SEL_CS:  rdata_o = cs_rd;
      SEL_WC:  rdata_o = wc_q;
      SEL_BA:  rdata_o = ba_q;
      SEL_DA:  rdata_o = da_q;
      SEL_DB:  rdata_o = db_q;
      default: rdata_o = '0;
    endcase
  end

  assign xfer_wc_o   = wc_q;
  assign xfer_addr_o = {cs_q[5:4], ba_q};
  assign xfer_da_o   = da_q;
  assign irq_lvl_o   = IRQ_LVL;
  assign irq_vec_o   = IRQ_VEC;

  // R6
  creset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.creset |=> (er_q == '0 && wc_q == '0 && da_q == '0 && db_q == '0));

  // R7
  pge_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.pge |=> (er_q == ER_PGE_V &&
                 !(start_write_o | start_read_o | start_wchk_o | start_lock_o)));

  // R8
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_write_o, start_read_o, start_wchk_o, start_lock_o}));

  // R8
  strobe_needs_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_write_o | start_read_o) |-> $past(launch));
endmodule

// File: tb/tb_dskc_regs.sv
module tb_dskc_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rst_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [1:0]  be_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        start_write_o, start_read_o, start_wchk_o, start_lock_o;
  logic [7:0]  lock_mask_o;
  logic [15:0] xfer_wc_o, xfer_da_o;
  logic [17:0] xfer_addr_o;
  logic        irq_o;
  logic [2:0]  irq_lvl_o;
  logic [8:0]  irq_vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  dskc_regs dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk_i);
    wr_en_i = 1'b0; be_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  function automatic logic [3:0] strobes();
    return {start_lock_o, start_wchk_o, start_read_o, start_write_o};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  exp_mask;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(3'd0, v); chk("R1 ds", v, 16'h09C0);
    rd(3'd1, v); chk("R1 er", v, 16'h0000);
    rd(3'd2, v); chk("R1 cs", v, 16'h0080);
    for (int i = 3; i < 8; i++) begin rd(3'(i), v); chk("R1 regs", v, 0); end
    chk("R1 mask", lock_mask_o, 0);
    chk("R1 strobes", {strobes(), irq_o}, 0);

    // R2 read/write map and unused index
    wr(3'd3, 16'h1234, 2'b11); rd(3'd3, v); chk("R2 wc", v, 16'h1234);
    wr(3'd4, 16'h5555, 2'b11); rd(3'd4, v); chk("R2 ba", v, 16'h5555);
    wr(3'd5, 16'hA00C, 2'b11); rd(3'd5, v); chk("R2 da", v, 16'hA00C);
    wr(3'd7, 16'hBEEF, 2'b11); rd(3'd7, v); chk("R2 db", v, 16'hBEEF);
    wr(3'd6, 16'hFFFF, 2'b11); rd(3'd6, v); chk("R2 idx6", v, 0);
    chk("R2 xfer", {xfer_wc_o, xfer_da_o}, 32'h1234A00C);

    // R5 byte merge on a data register
    wr(3'd3, 16'h77AB, 2'b01); rd(3'd3, v); chk("R5 lo merge", v, 16'h12AB);
    wr(3'd3, 16'hCD00, 2'b10); rd(3'd3, v); chk("R5 hi merge", v, 16'hCDAB);

    // R3 read-only registers
    wr(3'd0, 16'hFFFF, 2'b11); rd(3'd0, v); chk("R3 ds", v, 16'h09C0);
    wr(3'd1, 16'hFFFF, 2'b11); rd(3'd1, v); chk("R3 er", v, 0);
    rd(3'd2, v); chk("R3 cs err clear", v[15], 0);

    // R12 extended address
    wr(3'd2, 16'h0030, 2'b11); chk("R12 xfer_addr", xfer_addr_o, 18'h35555);
    rd(3'd2, v); chk("R4 ready", v, 16'h00B0);

    // R11 bus reset
    @(negedge clk_i); bus_rst_i = 1'b1; @(negedge clk_i); bus_rst_i = 1'b0;
    rd(3'd2, v); chk("R11 cs", v, 16'h0080);

    // R5 high-byte write to cs starts nothing, even with go in low data
    wr(3'd2, 16'h04FF, 2'b10);
    chk("R5 no start", strobes(), 0);
    rd(3'd2, v); chk("R5 hi cs", v, 16'h0480);
    // R7 stored format bit, then low-byte launch
    wr(3'd2, 16'h0003, 2'b01);
    chk("R7 no start", strobes(), 0);
    rd(3'd1, v); chk("R7 er", v, 16'h0800);
    rd(3'd2, v); chk("R4 err bit", v, 16'h8482);
    @(negedge clk_i); chk("R7 no irq", irq_o, 0);
    wr(3'd2, 16'h0843, 2'b11);
    chk("R7 single-loc", strobes(), 0);
    rd(3'd1, v); chk("R7 er sgl", v, 16'h0800);

    // R6 control reset
    wr(3'd3, 16'h1111, 2'b11);
    wr(3'd7, 16'h2222, 2'b11);
    wr(3'd2, 16'h0041, 2'b11);
    rd(3'd1, v); chk("R6 er", v, 0);
    rd(3'd2, v); chk("R6 cs", v, 16'h0080);
    rd(3'd3, v); chk("R6 wc", v, 0);
    rd(3'd5, v); chk("R6 da", v, 0);
    rd(3'd7, v); chk("R6 db", v, 0);
    rd(3'd4, v); chk("R6 ba kept", v, 16'h5555);
    rd(3'd0, v); chk("R6 ds", v, 16'h09C0);
    @(negedge clk_i); chk("R9 no irq on reset", irq_o, 0);

    // R8/R9 sweep every function with ie off and on, go set and clear
    for (int g = 0; g < 2; g++) begin
      for (int ie = 0; ie < 2; ie++) begin
        for (int fn = 0; fn < 8; fn++) begin
          logic [3:0] exp_st;
          wr(3'd2, 16'((ie << 6) | (fn << 1) | g), 2'b11);
          exp_st = '0;
          if (g == 1) begin
            case (fn)
              1: exp_st = 4'b0001;
              2: exp_st = 4'b0010;
              3: exp_st = 4'b0100;
              7: exp_st = 4'b1000;
              default: exp_st = '0;
            endcase
          end
          chk("R8 strobe", strobes(), exp_st);
          chk("R9 irq early", irq_o, 0);
          @(negedge clk_i);
          chk("R8 one cycle", strobes(), 0);
          chk("R9 irq", irq_o, (g == 1 && ie == 1 && fn != 0));
          @(negedge clk_i);
          chk("R9 irq one cycle", irq_o, 0);
        end
      end
    end
    chk("R9 lvl/vec", {irq_lvl_o, irq_vec_o}, {3'd5, 9'o220});
    chk("R10 mask drive0", lock_mask_o, 8'h01);

    // R10 lock every drive in turn
    exp_mask = 8'h01;
    for (int d = 7; d >= 0; d--) begin
      wr(3'd5, 16'(d << 13), 2'b11);
      chk("R10 before", lock_mask_o, exp_mask);
      wr(3'd2, 16'h000F, 2'b11);
      exp_mask = exp_mask | 8'(1 << d);
      chk("R10 mask", lock_mask_o, exp_mask);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule